// File: doc/BRIEF.md
# Lockable System Control Register File

A 32-bit register block on a simple APB-style bus with zero wait states, decoded in a 4 KiB window. It holds reset-control and clock-stop words with paired set and clear aliases, PLL parameter words, strap words that software can freeze, identity words, and a word that yields a new pseudo-random value each time it is read. An unlock-key word records whether the correct 32-bit key was last written to it.

Writes above the key word are always carried out. When the block is locked, such a write raises a sticky violation flag instead of being blocked. The strap words and the silicon-revision word take their values from input ports while reset is held. The key word's reset state also comes from an input port.

Top module: `sysctl_regfile`

## Requirements
- R1: During synchronous reset the block loads these values. Word 0x040 gets 0xF7C3FED8, 0x050 gets 0x0DFFFFFC, 0x080 gets 0xFFFF7F8A and 0x090 gets 0xFFF0FFF0. Word 0x200 gets 0x1000408F. The identity words get 0x1234ABCD at 0x5B0 and 0x88884444 at 0x5B4. Word 0x004 gets the FIXED_REV parameter (default 0x05030303). Word 0x014 gets `silicon_rev_i`. Word 0x500 gets `strap1_i` and word 0x510 gets `strap2_i`. The key word gets `unlock_init_i`.
- R2: A write to 0x000 stores 1 if the data equals UNLOCK_KEY (default 0x1688A8A8) and stores 0 otherwise. A read of 0x000 returns that bit in bit 0, with bits 31:1 at zero.
- R3: A write to 0x040, 0x050, 0x080 or 0x090 ORs the data into that word, so a bit that is already set stays set.
- R4: A write to 0x044, 0x054, 0x084 or 0x094 clears each bit of the word at (address − 4) where the data has a 1. Reads of these alias addresses return 0.
- R5: Strap words 0x500 and 0x510 are set by OR-writes and cleared through aliases at 0x504 and 0x514. While the protect word at strap address + 8 is nonzero, set-writes to that strap are ignored, but clear-writes still take effect. The protect words read back what was written to them and reset to 0.
- R6: Writes to 0x004, 0x014, 0x5B0, 0x5B4 and 0x540 change nothing. A write to 0x540 does not advance the random sequence.
- R7: Reads of 0x204, 0x224 and 0x244 return the stored word with bit 31 forced to 1. These words are writable and reset to 0. Their parameter partners at 0x200, 0x220 and 0x240 read back unmodified.
- R8: Each read of 0x540 returns the next state of a 32-bit right-shifting Galois LFSR, which then becomes the stored state. The next state is (s>>1) XOR 0xD0000001 when s[0] is 1, and s>>1 otherwise. The state starts at RNG_SEED (default 0x5EEDC0DE). The value written to the random-control word at 0x524 has no influence on this.
- R9: The following accesses read 0 and their writes are dropped: word index (address bits 11:2) at or above NUM_WORDS (default 384, that is addresses 0x600 and up), unmapped in-range addresses, and accesses with address bits 1:0 nonzero.
- R10: `lock_violation` is set one cycle after a completed aligned, in-range write to a word index other than 0 while the key bit is 0. The write itself is still performed. The flag stays set until reset.
- R11: `pready` is always 1. Read data is valid during the access phase of the same transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| pready | output | 1 | Always 1 |
| strap1_i | input | 32 | Reset value of strap word 0x500 |
| strap2_i | input | 32 | Reset value of strap word 0x510 |
| silicon_rev_i | input | 32 | Reset value of revision word 0x014 |
| unlock_init_i | input | 1 | Reset value of the key bit |
| lock_violation | output | 1 | Sticky flag for a write while locked |

## Verification
A write takes effect at the rising edge that ends its access phase. The bench therefore checks the result with a later read transfer, never in the cycle of the write. Read data, including the fresh random value, is combinational in the access phase, so the bench samples `prdata` 1 ns after the falling edge that opens that phase, before the edge that advances the LFSR. `lock_violation` is registered on the same edge as the offending write, so it is sampled after the write transfer has finished.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int IDX_W   = AW - 2;
    localparam int N_CTRL  = 4;
    localparam int N_STRAP = 2;
    localparam int N_SC    = N_CTRL + N_STRAP;
    localparam int N_PLAIN = 7;
    localparam int SEL_W   = 3;

    localparam logic [IDX_W-1:0] KEY_IDX     = 10'd0;
    localparam logic [IDX_W-1:0] REV_FIX_IDX = 10'd1;
    localparam logic [IDX_W-1:0] REV_IN_IDX  = 10'd5;
    localparam logic [IDX_W-1:0] RNG_IDX     = 10'd336;
    localparam logic [IDX_W-1:0] ID0_IDX     = 10'd364;
    localparam logic [IDX_W-1:0] ID1_IDX     = 10'd365;

    localparam logic [DW-1:0] LFSR_POLY = 32'hD000_0001;

    typedef enum logic [3:0] {
        RK_NONE, RK_KEY, RK_REV_FIX, RK_REV_IN, RK_SC_SET, RK_SC_CLR,
        RK_PROT, RK_PLAIN, RK_ID0, RK_ID1, RK_RNG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [SEL_W-1:0]  sel;
        logic              lock_ind;
        logic              in_range;
    } dec_t;

    // word index of each set/clear word; its clear alias sits one word above
    function automatic logic [IDX_W-1:0] sc_base(input int i);
        case (i)
            0:       return 10'd16;
            1:       return 10'd20;
            2:       return 10'd32;
            3:       return 10'd36;
            4:       return 10'd320;
            default: return 10'd324;
        endcase
    endfunction

    function automatic logic [DW-1:0] sc_reset(input int i);
        case (i)
            0:       return 32'hF7C3_FED8;
            1:       return 32'h0DFF_FFFC;
            2:       return 32'hFFFF_7F8A;
            default: return 32'hFFF0_FFF0;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] plain_idx(input int i);
        case (i)
            0:       return 10'd128;
            1:       return 10'd129;
            2:       return 10'd136;
            3:       return 10'd137;
            4:       return 10'd144;
            5:       return 10'd145;
            default: return 10'd329;
        endcase
    endfunction

    function automatic logic [DW-1:0] plain_reset(input int i);
        case (i)
            0:       return 32'h1000_408F;
            2:       return 32'h1008_405F;
            4:       return 32'h1004_077F;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic plain_locks(input int i);
        return (i == 1) || (i == 3) || (i == 5);
    endfunction

    function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_POLY) : (s >> 1);
    endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
    import sysctl_pkg::*;
#(
    parameter int NUM_WORDS = 384
) (
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);

    always_comb begin
        dec.kind     = RK_NONE;
        dec.sel      = '0;
        dec.lock_ind = 1'b0;
        dec.in_range = (int'(idx) < NUM_WORDS);
        if (dec.in_range) begin
            if (idx == KEY_IDX)     dec.kind = RK_KEY;
            if (idx == REV_FIX_IDX) dec.kind = RK_REV_FIX;
            if (idx == REV_IN_IDX)  dec.kind = RK_REV_IN;
            if (idx == RNG_IDX)     dec.kind = RK_RNG;
            if (idx == ID0_IDX)     dec.kind = RK_ID0;
            if (idx == ID1_IDX)     dec.kind = RK_ID1;
            for (int i = 0; i < N_SC; i++) begin
                if (idx == sc_base(i)) begin
                    dec.kind = RK_SC_SET;
                    dec.sel  = SEL_W'(i);
                end
                if (idx == sc_base(i) + 10'd1) begin
                    dec.kind = RK_SC_CLR;
                    dec.sel  = SEL_W'(i);
                end
                if (i >= N_CTRL && idx == sc_base(i) + 10'd2) begin
                    dec.kind = RK_PROT;
                    dec.sel  = SEL_W'(i - N_CTRL);
                end
            end
            for (int i = 0; i < N_PLAIN; i++) begin
                if (idx == plain_idx(i)) begin
                    dec.kind     = RK_PLAIN;
                    dec.sel      = SEL_W'(i);
                    dec.lock_ind = plain_locks(i);
                end
            end
        end
    end

endmodule

// File: rtl/sysctl_setclr_reg.sv
module sysctl_setclr_reg
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rst_val,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)         q <= rst_val;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end

endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0] SEED = 32'h5EED_C0DE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [DW-1:0] state
);

    localparam logic [DW-1:0] SAFE_SEED = (SEED == '0) ? 32'h1 : SEED;

    always_ff @(posedge clk) begin
        if (rst)      state <= SAFE_SEED;
        else if (adv) state <= lfsr_step(state);
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8,
    parameter int          NUM_WORDS  = 384,
    parameter logic [31:0] FIXED_REV  = 32'h0503_0303,
    parameter logic [31:0] CHIP_ID_LO = 32'h1234_ABCD,
    parameter logic [31:0] CHIP_ID_HI = 32'h8888_4444,
    parameter logic [31:0] RNG_SEED   = 32'h5EED_C0DE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    input  logic [31:0] strap1_i,
    input  logic [31:0] strap2_i,
    input  logic [31:0] silicon_rev_i,
    input  logic        unlock_init_i,
    output logic        lock_violation
);

    dec_t             dec;
    logic [IDX_W-1:0] word_idx;
    logic             aligned, acc, wr, rd;
    logic             unlocked_q;
    logic [DW-1:0]    rev_q;
    logic [DW-1:0]    rng_state, rng_fresh;
    logic [DW-1:0]    sc_q    [N_SC];
    logic [DW-1:0]    sc_rst  [N_SC];
    logic [N_SC-1:0]  set_ok, set_we, clr_we;
    logic [DW-1:0]    prot_q  [N_STRAP];
    logic [DW-1:0]    plain_q [N_PLAIN];

    assign word_idx = paddr[AW-1:2];
    assign aligned  = (paddr[1:0] == 2'b00);
    assign acc      = psel & penable & aligned;
    assign wr       = acc & pwrite;
    assign rd       = acc & ~pwrite;
    assign pready   = 1'b1;

    sysctl_addr_dec #(.NUM_WORDS(NUM_WORDS)) u_dec (
        .idx (word_idx),
        .dec (dec)
    );

    // key bit and sticky violation flag
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked_q     <= unlock_init_i;
            lock_violation <= 1'b0;
            rev_q          <= silicon_rev_i;
        end else begin
            if (wr && dec.kind == RK_KEY)
                unlocked_q <= (pwdata == UNLOCK_KEY);
            if (wr && dec.in_range && word_idx != KEY_IDX && !unlocked_q)
                lock_violation <= 1'b1;
        end
    end

    // set/clear words: four control words, then the two straps
    for (genvar i = 0; i < N_SC; i++) begin : g_sc
        if (i < N_CTRL) begin : g_ctrl
            assign sc_rst[i] = sc_reset(i);
            assign set_ok[i] = 1'b1;
        end else begin : g_strap
            assign sc_rst[i] = (i == N_CTRL) ? strap1_i : strap2_i;
            assign set_ok[i] = (prot_q[i-N_CTRL] == '0);
        end
        assign set_we[i] = wr && dec.kind == RK_SC_SET && dec.sel == SEL_W'(i) && set_ok[i];
        assign clr_we[i] = wr && dec.kind == RK_SC_CLR && dec.sel == SEL_W'(i);

        sysctl_setclr_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .rst_val (sc_rst[i]),
            .set_we  (set_we[i]),
            .clr_we  (clr_we[i]),
            .wdata   (pwdata),
            .q       (sc_q[i])
        );
    end

    for (genvar j = 0; j < N_STRAP; j++) begin : g_prot
        always_ff @(posedge clk) begin
            if (rst)
                prot_q[j] <= '0;
            else if (wr && dec.kind == RK_PROT && dec.sel == SEL_W'(j))
                prot_q[j] <= pwdata;
        end
    end

    for (genvar k = 0; k < N_PLAIN; k++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[k] <= plain_reset(k);
            else if (wr && dec.kind == RK_PLAIN && dec.sel == SEL_W'(k))
                plain_q[k] <= pwdata;
        end
    end

    sysctl_lfsr #(.SEED(RNG_SEED)) u_rng (
        .clk   (clk),
        .rst   (rst),
        .adv   (rd && dec.kind == RK_RNG),
        .state (rng_state)
    );
    assign rng_fresh = lfsr_step(rng_state);

    always_comb begin
        prdata = '0;
        if (aligned) begin
            case (dec.kind)
                RK_KEY:     prdata = {31'b0, unlocked_q};
                RK_REV_FIX: prdata = FIXED_REV;
                RK_REV_IN:  prdata = rev_q;
                RK_SC_SET:  prdata = sc_q[dec.sel];
                RK_PROT:    prdata = prot_q[dec.sel[0]];
                RK_PLAIN:   prdata = plain_q[dec.sel] | {dec.lock_ind, 31'b0};
                RK_ID0:     prdata = CHIP_ID_LO;
                RK_ID1:     prdata = CHIP_ID_HI;
                RK_RNG:     prdata = rng_fresh;
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
    parameter int NUM_WORDS = 384
) (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] prdata,
    input logic        lock_violation,
    input logic        unlocked,
    input logic [31:0] rng_state,
    input logic [31:0] ctrl0_q,
    input logic        ctrl0_clr,
    input logic [31:0] strap0_q,
    input logic [31:0] strap0_prot
);

    logic rd_acc, wr_acc;
    assign rd_acc = psel && penable && !pwrite;
    assign wr_acc = psel && penable && pwrite;

    assert_key_binary_R2: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr == 12'h000) |-> (prdata[31:1] == 31'b0));

    assert_w1s_keeps_bits_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl0_clr |=> ((ctrl0_q & $past(ctrl0_q)) == $past(ctrl0_q)));

    assert_prot_blocks_set_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && paddr == 12'h500 && strap0_prot != 32'h0) |=> $stable(strap0_q));

    assert_pll_lock_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && (paddr == 12'h204 || paddr == 12'h224 || paddr == 12'h244))
        |-> prdata[31]);

    assert_rng_advances_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && paddr == 12'h540) |=> (rng_state != $past(rng_state)));

    assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && int'(paddr[11:2]) >= NUM_WORDS) |-> (prdata == 32'h0));

    assert_locked_write_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && paddr[1:0] == 2'b00 && paddr[11:2] != 10'd0 &&
         int'(paddr[11:2]) < NUM_WORDS && !unlocked) |=> lock_violation);

    assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        lock_violation |=> lock_violation);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .psel           (psel),
    .penable        (penable),
    .pwrite         (pwrite),
    .paddr          (paddr),
    .prdata         (prdata),
    .lock_violation (lock_violation),
    .unlocked       (unlocked_q),
    .rng_state      (rng_state),
    .ctrl0_q        (sc_q[0]),
    .ctrl0_clr      (clr_we[0]),
    .strap0_q       (sc_q[4]),
    .strap0_prot    (prot_q[0])
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;

    localparam logic [31:0] KEY    = 32'h1688_A8A8;
    localparam logic [31:0] SEED   = 32'h5EED_C0DE;
    localparam logic [31:0] ST1    = 32'h0000_00A0;
    localparam logic [31:0] ST2    = 32'h0000_1200;
    localparam logic [31:0] SREV   = 32'h0503_0403;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        unlock_init = 1'b0;
    logic        lock_violation;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] rng_model;

    always #2.5 clk = ~clk;

    sysctl_regfile u0 (
        .clk            (clk),
        .rst            (rst),
        .psel           (psel),
        .penable        (penable),
        .pwrite         (pwrite),
        .paddr          (paddr),
        .pwdata         (pwdata),
        .prdata         (prdata),
        .pready         (pready),
        .strap1_i       (ST1),
        .strap2_i       (ST2),
        .silicon_rev_i  (SREV),
        .unlock_init_i  (unlock_init),
        .lock_violation (lock_violation)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'hD000_0001) : (s >> 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rng_model = SEED;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic rdy);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        rdy = pready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic        r;
        rd(a, d, r);
        chk(req, d, exp);
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        logic        r;
        rd(12'h040, d, r);
        chk("R1 ctrl 0x040", d, 32'hF7C3_FED8);
        chk("R11 pready", {31'b0, r}, 32'h1);
        rd_chk("R1 ctrl 0x050", 12'h050, 32'h0DFF_FFFC);
        rd_chk("R1 ctrl 0x080", 12'h080, 32'hFFFF_7F8A);
        rd_chk("R1 ctrl 0x090", 12'h090, 32'hFFF0_FFF0);
        rd_chk("R1 pll 0x200", 12'h200, 32'h1000_408F);
        rd_chk("R1 id lo", 12'h5B0, 32'h1234_ABCD);
        rd_chk("R1 id hi", 12'h5B4, 32'h8888_4444);
        rd_chk("R1 fixed rev", 12'h004, 32'h0503_0303);
        rd_chk("R1 rev port", 12'h014, SREV);
        rd_chk("R1 strap1", 12'h500, ST1);
        rd_chk("R1 strap2", 12'h510, ST2);
        rd_chk("R1 key init", 12'h000, 32'h0);
        chk("R10 flag after reset", {31'b0, lock_violation}, 32'h0);
    endtask

    task automatic t_key();
        wr(12'h000, 32'h1234_5678);
        rd_chk("R2 wrong key", 12'h000, 32'h0);
        chk("R10 key write not a violation", {31'b0, lock_violation}, 32'h0);
        wr(12'h000, KEY);
        rd_chk("R2 right key", 12'h000, 32'h1);
    endtask

    task automatic t_range();
        wr(12'h7FC, 32'hDEAD_BEEF);
        rd_chk("R9 beyond count", 12'h7FC, 32'h0);
        rd_chk("R9 top of window", 12'hFFC, 32'h0);
        wr(12'h300, 32'h1234_5678);
        rd_chk("R9 unmapped", 12'h300, 32'h0);
        wr(12'h202, 32'h0000_0000);
        rd_chk("R9 misaligned write dropped", 12'h200, 32'h1000_408F);
        rd_chk("R9 misaligned read", 12'h202, 32'h0);
        chk("R10 unlocked writes", {31'b0, lock_violation}, 32'h0);
    endtask

    task automatic t_setclr();
        wr(12'h050, 32'h1000_0001);
        rd_chk("R3 set 0x050", 12'h050, 32'h1DFF_FFFD);
        wr(12'h050, 32'h0);
        rd_chk("R3 zero keeps bits", 12'h050, 32'h1DFF_FFFD);
        wr(12'h044, 32'h0000_FF00);
        rd_chk("R4 clear 0x040", 12'h040, 32'hF7C3_00D8);
        wr(12'h094, 32'hFFF0_0000);
        rd_chk("R4 clear 0x090", 12'h090, 32'h0000_FFF0);
        rd_chk("R4 alias reads 0", 12'h044, 32'h0);
    endtask

    task automatic t_strap();
        wr(12'h500, 32'h0000_0005);
        rd_chk("R5 strap set", 12'h500, 32'h0000_00A5);
        wr(12'h508, 32'h1);
        rd_chk("R5 prot readback", 12'h508, 32'h1);
        wr(12'h500, 32'h0000_0100);
        rd_chk("R5 protected set ignored", 12'h500, 32'h0000_00A5);
        wr(12'h504, 32'h0000_0080);
        rd_chk("R5 clear while protected", 12'h500, 32'h0000_0025);
        wr(12'h510, 32'h0000_0001);
        rd_chk("R5 strap2 unaffected by prot1", 12'h510, 32'h0000_1201);
        wr(12'h514, 32'h0000_0200);
        rd_chk("R5 strap2 clear", 12'h510, 32'h0000_1001);
    endtask

    task automatic t_readonly();
        wr(12'h5B0, 32'h0);
        rd_chk("R6 id lo", 12'h5B0, 32'h1234_ABCD);
        wr(12'h5B4, 32'h0);
        rd_chk("R6 id hi", 12'h5B4, 32'h8888_4444);
        wr(12'h004, 32'h0);
        rd_chk("R6 fixed rev", 12'h004, 32'h0503_0303);
        wr(12'h014, 32'h0);
        rd_chk("R6 rev port", 12'h014, SREV);
        wr(12'h540, 32'hFFFF_FFFF);
        rng_model = step(rng_model);
        rd_chk("R6 rng write no effect", 12'h540, rng_model);
    endtask

    task automatic t_pll();
        wr(12'h204, 32'h0000_0012);
        rd_chk("R7 ext lock bit", 12'h204, 32'h8000_0012);
        rd_chk("R7 ext 0x224", 12'h224, 32'h8000_0000);
        rd_chk("R7 ext 0x244", 12'h244, 32'h8000_0000);
        rd_chk("R7 param untouched", 12'h220, 32'h1008_405F);
        wr(12'h240, 32'h0000_0042);
        rd_chk("R7 param write", 12'h240, 32'h0000_0042);
    endtask

    task automatic t_rng();
        rng_model = step(rng_model);
        rd_chk("R8 first read", 12'h540, rng_model);
        rng_model = step(rng_model);
        rd_chk("R8 second read", 12'h540, rng_model);
        wr(12'h524, 32'h0);
        rd_chk("R8 ctrl readback", 12'h524, 32'h0);
        rng_model = step(rng_model);
        rd_chk("R8 read with ctrl 0", 12'h540, rng_model);
    endtask

    task automatic t_violation();
        wr(12'h000, 32'h0);
        rd_chk("R2 relock", 12'h000, 32'h0);
        chk("R10 no flag yet", {31'b0, lock_violation}, 32'h0);
        wr(12'hFFC, 32'h1);
        chk("R10 out of range no flag", {31'b0, lock_violation}, 32'h0);
        wr(12'h054, 32'h0000_000C);
        chk("R10 flag set", {31'b0, lock_violation}, 32'h1);
        rd_chk("R10 write still done", 12'h050, 32'h1DFF_FFF1);
        wr(12'h000, KEY);
        chk("R10 flag sticky", {31'b0, lock_violation}, 32'h1);
    endtask

    task automatic t_reset_again();
        unlock_init = 1'b1;
        do_reset();
        chk("R10 flag cleared by reset", {31'b0, lock_violation}, 32'h0);
        rd_chk("R1 key init high", 12'h000, 32'h1);
        rd_chk("R1 ctrl restored", 12'h050, 32'h0DFF_FFFC);
        rd_chk("R1 strap restored", 12'h500, ST1);
        rd_chk("R1 prot restored", 12'h508, 32'h0);
        rng_model = step(rng_model);
        rd_chk("R8 seed restored", 12'h540, rng_model);
        wr(12'h300, 32'h1);
        chk("R10 unlocked at reset", {31'b0, lock_violation}, 32'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        t_reset_values();
        t_key();
        t_range();
        t_setclr();
        t_strap();
        t_readonly();
        t_pll();
        t_rng();
        t_violation();
        t_reset_again();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule